// File: doc/BRIEF.md
# Command-Programmable March BIST

This block runs a March memory test on one external single-port RAM. The algorithm is not fixed. The test is delivered as a series of short commands on a serial line, one March element at a time. A command controller collects each command bit by bit. When the command is complete, it hands the command to a pattern-generator state machine and waits for it to finish. The pattern generator sweeps the whole address range in the direction the command selects. At each address it performs every read and write of the chosen operation sequence before it moves to the next address. Every read is compared against the data it expects.

A command has 9 bits: {dir, op, bg}. It is shifted in MSB first, one bit per clock while `bsc` is high. Bit 8 is the sweep direction. Bits 7:4 select one of the sixteen operation-sequence codes. Bits 3:0 are a data background, which is replicated across the RAM word. A null code ends the program with a pass. The first read mismatch ends it with a fail. Both results stay until `bist_rst` is pulsed.

Controller states and transitions:
- CT_IDLE → CT_SHIFT on the first `bsc` bit, unless a result is already held.
- CT_SHIFT → CT_LOAD when `bsc` drops.
- CT_LOAD → CT_RUN.
- CT_RUN asserts the enable to the pattern generator and returns to CT_IDLE when it reports done.

Pattern-generator states and transitions:
- TG_IDLE → TG_INIT on enable. TG_INIT loads the start address.
- TG_INIT → TG_IFETCH. TG_IFETCH decodes the sequence code. It goes to TG_PASS on a null code, otherwise to TG_DFETCH.
- TG_DFETCH builds the data word and goes to TG_EXEC.
- TG_EXEC issues one operation. A read goes to TG_CMP. A write goes to the next operation, or back to TG_IDLE at the end of the element.
- TG_CMP goes to TG_FAIL on a mismatch. Otherwise it continues like a write.
- TG_PASS and TG_FAIL hold until `bist_rst`.

Top module: `mbist_top`

## Requirements
- R1: A command is the last 9 bits sampled on `bsi` while `bsc` is high, MSB first. The fields are dir = bit 8, op = bits 7:4, bg = bits 3:0. `bist_busy` rises after the first sampled bit and falls after the element has finished.
- R2: The true data word is bg repeated across the RAM width. The primed word is its bitwise inverse.
- R3: dir = 0 sweeps the addresses from 0 up to the top address. dir = 1 sweeps from the top address down to 0.
- R4: All operations of the sequence are done at one address before the address moves by exactly one. An element over N words therefore makes N × (reads per sequence) reads and N × (writes per sequence) writes.
- R5: The sequence codes are as follows (a = true word, a' = primed word).
  - 1: w a
  - 2: w a'
  - 3: r a
  - 4: r a'
  - 5: r a, w a'
  - 6: r a', w a
  - 7: r a, w a', r a'
  - 8: r a', w a, r a
  - 9: w a, r a, w a', r a'
  - 10: w a', r a', w a, r a
  - 11: r a, w a', r a', w a
  - 12: r a', w a, r a, w a'
- R6: Codes 0, 13, 14 and 15 are null. A null code makes no RAM access and ends the test with `bist_end` = 1 and `bist_go` = 1.
- R7: The first read whose data differs from the expected word ends the test with `bist_end` = 1 and `bist_go` = 0. No RAM access follows it.
- R8: `bist_end` and `bist_go` hold their values until `bist_rst`. A command sent while a result is held causes no RAM access and leaves `bist_busy` low. `bist_rst` clears the result and stops any element in progress.
- R9: After reset, `bist_end`, `bist_go`, `bist_busy`, `ram_we` and `ram_re` are all 0.
- R10: A read issued with `ram_re` is compared against `ram_rdata` one cycle later. `ram_we` and `ram_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bist_rst | input | 1 | Synchronous clear of the result and of all state |
| bsc | input | 1 | Shift enable for the serial command |
| bsi | input | 1 | Serial command data, MSB first |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe; the data returns on the next cycle |
| ram_rdata | input | DW | RAM read data |
| bist_busy | output | 1 | A command is being received or executed |
| bist_end | output | 1 | The test has finished |
| bist_go | output | 1 | The test passed (valid while bist_end is 1) |

## Verification
Every sequence code from 1 to 12 is run in both directions. A preceding element puts the RAM in the state that the code's first read expects. Each run checks the read and write counts, which separate the codes. The first and last addresses touched, and the single-step address moves, separate the two directions. The final RAM contents separate true from primed writes. All sixteen backgrounds are swept with a write/read/write/read sequence to confirm the replication. A bench-side stuck-at bit checks that the test halts at the exact failing read. A full March program ending in each null code, commands sent after a result, and a clear in the middle of an element cover the ending and the holding of the result.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    localparam int OP_W  = 4;
    localparam int BG_W  = 4;
    localparam int CMD_W = 1 + OP_W + BG_W;

    typedef enum logic [1:0] {CT_IDLE, CT_SHIFT, CT_LOAD, CT_RUN} ctl_state_t;

    typedef enum logic [2:0] {
        TG_IDLE, TG_INIT, TG_IFETCH, TG_DFETCH,
        TG_EXEC, TG_CMP, TG_PASS, TG_FAIL
    } tpg_state_t;

    // one micro-operation: rd=1 read, inv=1 primed data
    typedef struct packed {
        logic rd;
        logic inv;
    } mop_t;

    // sequence length, 0 means null code
    function automatic logic [2:0] seq_len(input logic [OP_W-1:0] op);
        unique case (op)
            4'd1, 4'd2, 4'd3, 4'd4:    seq_len = 3'd1;
            4'd5, 4'd6:                seq_len = 3'd2;
            4'd7, 4'd8:                seq_len = 3'd3;
            4'd9, 4'd10, 4'd11, 4'd12: seq_len = 3'd4;
            default:                   seq_len = 3'd0;
        endcase
    endfunction

    // step 0 sits in bits 7:6, encoded {rd,inv}
    function automatic logic [7:0] seq_pat(input logic [OP_W-1:0] op);
        unique case (op)
            4'd1:    seq_pat = 8'b00_00_00_00;
            4'd2:    seq_pat = 8'b01_00_00_00;
            4'd3:    seq_pat = 8'b10_00_00_00;
            4'd4:    seq_pat = 8'b11_00_00_00;
            4'd5:    seq_pat = 8'b10_01_00_00;
            4'd6:    seq_pat = 8'b11_00_00_00;
            4'd7:    seq_pat = 8'b10_01_11_00;
            4'd8:    seq_pat = 8'b11_00_10_00;
            4'd9:    seq_pat = 8'b00_10_01_11;
            4'd10:   seq_pat = 8'b01_11_00_10;
            4'd11:   seq_pat = 8'b10_01_11_00;
            4'd12:   seq_pat = 8'b11_00_10_01;
            default: seq_pat = 8'b00_00_00_00;
        endcase
    endfunction

    function automatic mop_t seq_step(input logic [OP_W-1:0] op, input logic [1:0] idx);
        logic [7:0] p;
        p = seq_pat(op);
        seq_step = mop_t'(p[7 - 2*idx -: 2]);
    endfunction

endpackage

// File: rtl/mbist_ctl.sv
module mbist_ctl
    import mbist_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bsc,
    input  logic             bsi,
    input  logic             halt,
    input  logic             done,
    output logic             ena,
    output logic             busy,
    output logic [CMD_W-1:0] cmd
);

    ctl_state_t st, nxt;
    logic       shift_en;

    assign shift_en = bsc && ((st == CT_IDLE && !halt) || st == CT_SHIFT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st <= CT_IDLE;
        else if (clr) st <= CT_IDLE;
        else          st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            CT_IDLE:  if (bsc && !halt) nxt = CT_SHIFT;
            CT_SHIFT: if (!bsc) nxt = CT_LOAD;
            CT_LOAD:  nxt = CT_RUN;
            CT_RUN:   if (done) nxt = CT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cmd <= '0;
        else if (clr)      cmd <= '0;
        else if (shift_en) cmd <= {cmd[CMD_W-2:0], bsi};
    end

    always_comb begin
        ena  = (st == CT_RUN);
        busy = (st != CT_IDLE);
    end

    // handshake: enable stays up until the generator answers (R1)
    p_ena_held_r1: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (ena && !done) |=> ena);

endmodule

// File: rtl/mbist_tpg.sv
module mbist_tpg
    import mbist_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ena,
    input  logic [CMD_W-1:0] cmd,
    input  logic [DW-1:0]    ram_rdata,
    output logic             done,
    output logic             fin,
    output logic             pass,
    output logic [AW-1:0]    ram_addr,
    output logic [DW-1:0]    ram_wdata,
    output logic             ram_we,
    output logic             ram_re
);

    localparam int          REP  = DW / BG_W;
    localparam logic [AW-1:0] AMAX = {AW{1'b1}};

    tpg_state_t      st, nxt;
    logic [AW-1:0]   addr;
    logic            dirq;
    logic [OP_W-1:0] opq;
    logic [DW-1:0]   word;
    logic [1:0]      idx;
    logic            done_q;

    logic            cmd_dir;
    logic [OP_W-1:0] cmd_op;
    logic [BG_W-1:0] cmd_bg;
    mop_t            step;
    logic [DW-1:0]   expect_w;
    logic            last_step, last_addr, elem_end, mismatch, adv;

    assign cmd_dir = cmd[CMD_W-1];
    assign cmd_op  = cmd[BG_W +: OP_W];
    assign cmd_bg  = cmd[BG_W-1:0];

    always_comb begin
        step      = seq_step(opq, idx);
        expect_w  = step.inv ? ~word : word;
        last_step = ({1'b0, idx} == (seq_len(opq) - 3'd1));
        last_addr = dirq ? (addr == '0) : (addr == AMAX);
        elem_end  = last_step && last_addr;
        mismatch  = (ram_rdata != expect_w);
        adv       = (st == TG_EXEC && !step.rd) || (st == TG_CMP && !mismatch);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st <= TG_IDLE;
        else if (clr) st <= TG_IDLE;
        else          st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            TG_IDLE:   if (ena && !done_q) nxt = TG_INIT;
            TG_INIT:   nxt = TG_IFETCH;
            TG_IFETCH: nxt = (seq_len(cmd_op) == 3'd0) ? TG_PASS : TG_DFETCH;
            TG_DFETCH: nxt = TG_EXEC;
            TG_EXEC: begin
                if (step.rd)       nxt = TG_CMP;
                else if (elem_end) nxt = TG_IDLE;
            end
            TG_CMP: begin
                if (mismatch)      nxt = TG_FAIL;
                else if (elem_end) nxt = TG_IDLE;
                else               nxt = TG_EXEC;
            end
            TG_PASS, TG_FAIL: nxt = st;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr   <= '0;
            dirq   <= 1'b0;
            opq    <= '0;
            word   <= '0;
            idx    <= '0;
            done_q <= 1'b0;
        end else if (clr) begin
            done_q <= 1'b0;
            idx    <= '0;
        end else begin
            if (!ena) done_q <= 1'b0;
            if (st == TG_INIT) begin
                dirq <= cmd_dir;
                addr <= cmd_dir ? AMAX : '0;
            end
            if (st == TG_IFETCH) opq <= cmd_op;
            if (st == TG_DFETCH) begin
                word <= {REP{cmd_bg}};
                idx  <= '0;
            end
            if (adv) begin
                if (!last_step) begin
                    idx <= idx + 2'd1;
                end else if (last_addr) begin
                    done_q <= 1'b1;
                end else begin
                    idx  <= '0;
                    addr <= dirq ? addr - 1'b1 : addr + 1'b1;
                end
            end
        end
    end

    always_comb begin
        fin       = (st == TG_PASS) || (st == TG_FAIL);
        pass      = (st == TG_PASS);
        done      = done_q || fin;
        ram_addr  = addr;
        ram_wdata = expect_w;
        ram_we    = (st == TG_EXEC) && !step.rd;
        ram_re    = (st == TG_EXEC) && step.rd;
    end

    // a read is always followed by its compare cycle (R10)
    p_read_compared_r10: assert property (@(posedge clk) disable iff (!rst_n || clr)
        ram_re |=> (st == TG_CMP));

    p_rw_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

endmodule

// File: rtl/mbist_top.sv
module mbist_top
    import mbist_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bist_rst,
    input  logic          bsc,
    input  logic          bsi,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          ram_we,
    output logic          ram_re,
    input  logic [DW-1:0] ram_rdata,
    output logic          bist_busy,
    output logic          bist_end,
    output logic          bist_go
);

    logic             ena, done, fin, pass;
    logic [CMD_W-1:0] cmd;

    mbist_ctl u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (bist_rst),
        .bsc   (bsc),
        .bsi   (bsi),
        .halt  (fin),
        .done  (done),
        .ena   (ena),
        .busy  (bist_busy),
        .cmd   (cmd)
    );

    mbist_tpg #(.AW(AW), .DW(DW)) u_tpg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (bist_rst),
        .ena       (ena),
        .cmd       (cmd),
        .ram_rdata (ram_rdata),
        .done      (done),
        .fin       (fin),
        .pass      (pass),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_we    (ram_we),
        .ram_re    (ram_re)
    );

    assign bist_end = fin;
    assign bist_go  = pass;

    p_end_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_end && !bist_rst) |=> bist_end);

    p_go_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_end && !bist_rst) |=> $stable(bist_go));

    p_silent_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bist_end |-> !(ram_we || ram_re));

    p_go_implies_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bist_go |-> bist_end);

endmodule

// File: tb/mbist_top_tb_top.sv
module mbist_top_tb_top;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bist_rst = 1'b0;
    logic          bsc = 1'b0;
    logic          bsi = 1'b0;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic          ram_we, ram_re;
    logic [DW-1:0] ram_rdata;
    logic          bist_busy, bist_end, bist_go;

    always #5 clk = ~clk;

    mbist_top #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bist_rst(bist_rst), .bsc(bsc), .bsi(bsi),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re),
        .ram_rdata(ram_rdata), .bist_busy(bist_busy), .bist_end(bist_end), .bist_go(bist_go)
    );

    // RAM model with optional stuck-at-1 bit on reads
    logic [DW-1:0] mem [NW];
    logic          flt_en = 1'b0;
    int            flt_addr = 0;
    int            flt_bit = 0;

    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (ram_re) begin
            if (flt_en && int'(ram_addr) == flt_addr)
                ram_rdata <= mem[ram_addr] | DW'(1 << flt_bit);
            else
                ram_rdata <= mem[ram_addr];
        end
    end

    // access monitor
    logic mon_clr = 1'b0;
    logic mon_dir = 1'b0;
    int n_rd, n_wr, n_chg, n_bad, n_both, first_a, last_a;
    logic have_a;

    always @(posedge clk) begin
        if (mon_clr) begin
            n_rd = 0; n_wr = 0; n_chg = 0; n_bad = 0; n_both = 0;
            first_a = -1; last_a = -1; have_a = 1'b0;
        end else if (ram_we || ram_re) begin
            if (ram_we) n_wr++;
            if (ram_re) n_rd++;
            if (ram_we && ram_re) n_both++;
            if (!have_a) begin
                first_a = int'(ram_addr);
                have_a  = 1'b1;
            end else if (int'(ram_addr) != last_a) begin
                n_chg++;
                if (int'(ram_addr) != (mon_dir ? last_a - 1 : last_a + 1)) n_bad++;
            end
            last_a = int'(ram_addr);
        end
    end

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic mon_reset(input logic d);
        @(negedge clk);
        mon_dir = d;
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic send(input logic d, input int op, input int bg);
        logic [8:0] c;
        c = {d, 4'(op), 4'(bg)};
        @(negedge clk);
        for (int i = 8; i >= 0; i--) begin
            bsc = 1'b1;
            bsi = c[i];
            @(negedge clk);
        end
        bsc = 1'b0;
        bsi = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 2000 && bist_busy; k++) @(negedge clk);
    endtask

    // expected per-code properties, from the code table in R5
    function automatic int e_rd(input int op);
        case (op)
            1, 2: return 0;
            3, 4, 5, 6: return 1;
            default: return 2;
        endcase
    endfunction
    function automatic int e_wr(input int op);
        case (op)
            3, 4: return 0;
            1, 2, 5, 6, 7, 8: return 1;
            default: return 2;
        endcase
    endfunction
    function automatic bit e_pre_inv(input int op);
        return (op == 4 || op == 6 || op == 8 || op == 12);
    endfunction
    function automatic bit e_fin_inv(input int op);
        case (op)
            2, 4, 5, 7, 9, 12: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
    function automatic logic [DW-1:0] word_of(input int bg, input bit inv);
        logic [DW-1:0] w;
        w = {4'(bg), 4'(bg)};
        return inv ? ~w : w;
    endfunction

    function automatic int mem_mismatch(input logic [DW-1:0] w);
        int n = 0;
        for (int a = 0; a < NW; a++) if (mem[a] !== w) n++;
        return n;
    endfunction

    task automatic clear_bist;
        @(negedge clk);
        bist_rst = 1'b1;
        @(negedge clk);
        bist_rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(bist_end == 0, "R9 bist_end after reset", bist_end, 0);
        chk(bist_go == 0, "R9 bist_go after reset", bist_go, 0);
        chk(bist_busy == 0, "R9 bist_busy after reset", bist_busy, 0);
        chk(ram_we == 0 && ram_re == 0, "R9 ram strobes after reset", ram_we + ram_re, 0);

        // R3 R4 R5: every code, both directions
        for (int op = 1; op <= 12; op++) begin
            for (int d = 0; d < 2; d++) begin
                int bg = (op * 3 + d * 5) & 15;
                send(~d[0], e_pre_inv(op) ? 2 : 1, bg);
                mon_reset(d[0]);
                send(d[0], op, bg);
                chk(n_rd == NW * e_rd(op), $sformatf("R5 reads op%0d dir%0d", op, d), n_rd, NW * e_rd(op));
                chk(n_wr == NW * e_wr(op), $sformatf("R5 writes op%0d dir%0d", op, d), n_wr, NW * e_wr(op));
                chk(first_a == (d ? NW - 1 : 0), $sformatf("R3 first addr op%0d dir%0d", op, d), first_a, d ? NW - 1 : 0);
                chk(last_a == (d ? 0 : NW - 1), $sformatf("R3 last addr op%0d dir%0d", op, d), last_a, d ? 0 : NW - 1);
                chk(n_chg == NW - 1 && n_bad == 0, $sformatf("R4 address steps op%0d dir%0d", op, d), n_chg * 100 + n_bad, (NW - 1) * 100);
                chk(mem_mismatch(word_of(bg, e_fin_inv(op))) == 0, $sformatf("R2 final contents op%0d dir%0d", op, d),
                    mem_mismatch(word_of(bg, e_fin_inv(op))), 0);
                chk(n_both == 0, "R10 no read and write together", n_both, 0);
                chk(!bist_end && !bist_busy, $sformatf("R1 element completes op%0d", op), {bist_end, bist_busy}, 0);
            end
        end

        // R2: every background with w a, r a, w a', r a'
        for (int bg = 0; bg < 16; bg++) begin
            send(1'b0, 9, bg);
            chk(mem_mismatch(word_of(bg, 1'b1)) == 0, $sformatf("R2 background %0d", bg), mem_mismatch(word_of(bg, 1'b1)), 0);
            chk(!bist_end, $sformatf("R10 reads match bg %0d", bg), bist_end, 0);
        end

        // R6: March program closed by each null code
        for (int nc = 0; nc < 4; nc++) begin
            int code = (nc == 0) ? 0 : 12 + nc;
            clear_bist();
            chk(!bist_end && !bist_go, "R8 clear drops result", {bist_end, bist_go}, 0);
            send(1'b0, 1, 0);
            send(1'b0, 5, 0);
            send(1'b0, 6, 0);
            send(1'b1, 5, 0);
            send(1'b1, 6, 0);
            send(1'b1, 3, 0);
            mon_reset(1'b0);
            send(1'b0, code, 7);
            chk(bist_end && bist_go, $sformatf("R6 null code %0d passes", code), {bist_end, bist_go}, 3);
            chk(n_rd + n_wr == 0, $sformatf("R6 null code %0d no access", code), n_rd + n_wr, 0);
        end

        // R8: commands ignored while a result is held
        mon_reset(1'b0);
        send(1'b0, 1, 5);
        chk(n_wr == 0, "R8 no writes after end", n_wr, 0);
        chk(bist_busy == 0, "R8 busy stays low after end", bist_busy, 0);
        chk(bist_end && bist_go, "R8 result held", {bist_end, bist_go}, 3);
        chk(mem_mismatch(word_of(0, 1'b0)) == 0, "R8 memory untouched", mem_mismatch(word_of(0, 1'b0)), 0);

        // R7: stuck-at-1 on bit 2 of address 9
        clear_bist();
        send(1'b0, 1, 0);
        flt_en = 1'b1; flt_addr = 9; flt_bit = 2;
        mon_reset(1'b0);
        send(1'b0, 5, 0);
        chk(bist_end && !bist_go, "R7 fail result", {bist_end, bist_go}, 2);
        chk(n_rd == 10, "R7 reads up to failing address", n_rd, 10);
        chk(n_wr == 9, "R7 writes before failing address", n_wr, 9);
        repeat (20) @(negedge clk);
        chk(n_rd == 10 && n_wr == 9, "R7 no access after fail", n_rd + n_wr, 19);
        chk(bist_end && !bist_go, "R8 fail result held", {bist_end, bist_go}, 2);
        flt_en = 1'b0;

        // R8: clear in the middle of an element
        clear_bist();
        fork
            send(1'b0, 9, 3);
            begin
                repeat (30) @(negedge clk);
                bist_rst = 1'b1;
                @(negedge clk);
                bist_rst = 1'b0;
            end
        join
        mon_reset(1'b0);
        repeat (10) @(negedge clk);
        chk(bist_busy == 0, "R8 clear stops element", bist_busy, 0);
        chk(n_rd + n_wr == 0, "R8 no access after clear", n_rd + n_wr, 0);
        chk(!bist_end, "R8 no result after clear", bist_end, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule